// File: doc/BRIEF.md
# Row-Scan PWM Driver

This block scans a row-multiplexed LED matrix. Only one row conducts at a time. It reads one row of 4-bit brightness values from an external frame buffer and drives a parallel vector of column enables. Each enable stays on for a time that matches the pixel's brightness. The row currently sunk to ground is chosen by an external serial-in shift register. The block shifts a one-hot row pattern into that register and then strobes its output latch.

Each row takes one time slot, in three phases:

1. A blanked load phase. The serial pattern is shifted out and latched, and the pixel row is captured.
2. A scan phase of fifteen PWM ticks, each `TICK_DIV` clock cycles long.
3. A move to the next row.

Rows are visited in ascending order. When the last row's scan ends, a one-cycle frame-end pulse marks a safe point for the buffer owner to swap frames.

Top module: `rowScanPwm`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `colEn` is all zero and `srClk`, `srLatch` and `frameEnd` are low. The first row loaded after reset is row 0.
- R2: Each row load sends exactly `NUM_ROWS` single-cycle `srClk` pulses and then one single-cycle `srLatch` pulse. `srData` is valid while `srClk` is high. The highest row's bit goes out first, so a shift register that moves toward its high bit holds bit r set and all other bits clear when row r is loaded.
- R3: Rows are loaded in ascending order from 0 to `NUM_ROWS-1`, then wrap back to 0.
- R4: During the `srLatch` cycle, `fbRowAddr` equals the row being loaded. The design captures `fbRowData` at the end of that cycle. Column c uses bits `[c*LEVEL_BITS +: LEVEL_BITS]`.
- R5: The scan slot is the 15·`TICK_DIV` cycles that directly follow `srLatch`. In cycle k of the slot (counting from 1), `colEn[c]` is high exactly when (k-1)/`TICK_DIV` is less than the captured value v. So column c is lit for v·`TICK_DIV` cycles, starting at the beginning of the slot.
- R6: A value of 0 keeps its column dark for the whole slot. A value of 15 keeps it lit for the whole slot.
- R7: `colEn` is all zero in every cycle outside a scan slot, including every `srClk` and `srLatch` cycle.
- R8: `frameEnd` is a single-cycle pulse. It occurs only in the last scan cycle of row `NUM_ROWS-1`, so there is exactly one pulse per frame.
- R9: Changes to the frame buffer after the `srLatch` cycle do not affect the row being scanned. This includes a whole-frame swap at `frameEnd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fbRowAddr | output | ROW_W | Row index presented to the frame buffer |
| fbRowData | input | NUM_COLS*LEVEL_BITS | Brightness values of the addressed row |
| colEn | output | NUM_COLS | Column current-source enables for the active row |
| srData | output | 1 | Serial row-pattern bit |
| srClk | output | 1 | Shift clock for the external row register |
| srLatch | output | 1 | Output-latch strobe for the external row register |
| frameEnd | output | 1 | One-cycle pulse at the end of each full frame |

## Verification
The frame-end pulse falls in the same cycle as the final PWM tick of the last row. Columns at level 15 are still lit in that cycle. The buffer owner also reacts to that pulse by replacing the whole frame, so a swap can race with a row still in flight.

The bench provokes both at once. On every `frameEnd` it loads a new frame, and it also pokes random cells in the middle of scan slots. It then checks three things:
- The pulse lands exactly on slot cycle 15·`TICK_DIV` of the last row.
- Each column's on-time still matches the value snapshotted in the `srLatch` cycle.
- Row 0 of the following frame picks up the new contents.

// File: rtl/rowScanPkg.sv
package rowScanPkg;

  typedef enum logic [1:0] {
    PH_SHIFT = 2'd0,
    PH_LATCH = 2'd1,
    PH_SCAN  = 2'd2
  } scanPhase_t;

  typedef struct packed {
    logic loadPixels;
    logic scanOn;
  } scanStrobes_t;

endpackage

// File: rtl/rowScanCtrl.sv
module rowScanCtrl
  import rowScanPkg::*;
#(
  parameter int NUM_ROWS   = 8,
  parameter int LEVEL_BITS = 4,
  parameter int TICK_DIV   = 3,
  localparam int ROW_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  output scanStrobes_t          strobes,
  output logic [LEVEL_BITS-1:0] tick,
  output logic [ROW_W-1:0]      rowIdx,
  output logic                  srData,
  output logic                  srClk,
  output logic                  srLatch,
  output logic                  frameEnd
);

  localparam int NUM_TICKS = (1 << LEVEL_BITS) - 1;
  localparam int DIV_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [ROW_W-1:0]      LAST_ROW  = ROW_W'(NUM_ROWS - 1);
  localparam logic [LEVEL_BITS-1:0] LAST_TICK = LEVEL_BITS'(NUM_TICKS - 1);
  localparam logic [DIV_W-1:0]      LAST_DIV  = DIV_W'(TICK_DIV - 1);

  scanPhase_t       phase;
  logic [ROW_W-1:0] bitIdx;
  logic             clkHigh;
  logic [DIV_W-1:0] divCnt;
  logic             tickDone;
  logic             slotDone;

  assign tickDone = (divCnt == LAST_DIV);
  assign slotDone = tickDone && (tick == LAST_TICK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_SHIFT;
      bitIdx  <= '0;
      clkHigh <= 1'b0;
      divCnt  <= '0;
      tick    <= '0;
      rowIdx  <= '0;
    end else begin
      unique case (phase)
        PH_SHIFT: begin
          clkHigh <= ~clkHigh;
          if (clkHigh) begin
            if (bitIdx == LAST_ROW) begin
              bitIdx <= '0;
              phase  <= PH_LATCH;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        PH_LATCH: begin
          phase  <= PH_SCAN;
          divCnt <= '0;
          tick   <= '0;
        end
        PH_SCAN: begin
          if (tickDone) begin
            divCnt <= '0;
            if (tick == LAST_TICK) begin
              tick   <= '0;
              phase  <= PH_SHIFT;
              rowIdx <= (rowIdx == LAST_ROW) ? '0 : rowIdx + 1'b1;
            end else begin
              tick <= tick + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: phase <= PH_SHIFT;
      endcase
    end
  end

  // Highest-row bit leaves first so the far end of the register holds it.
  assign srData   = (phase == PH_SHIFT) && (rowIdx == (LAST_ROW - bitIdx));
  assign srClk    = (phase == PH_SHIFT) && clkHigh;
  assign srLatch  = (phase == PH_LATCH);
  assign frameEnd = (phase == PH_SCAN) && slotDone && (rowIdx == LAST_ROW);

  assign strobes.loadPixels = (phase == PH_LATCH);
  assign strobes.scanOn     = (phase == PH_SCAN);

endmodule

// File: rtl/rowScanData.sv
module rowScanData
  import rowScanPkg::*;
#(
  parameter int NUM_COLS   = 8,
  parameter int LEVEL_BITS = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  scanStrobes_t                   strobes,
  input  logic [LEVEL_BITS-1:0]          tick,
  input  logic [NUM_COLS*LEVEL_BITS-1:0] rowData,
  output logic [NUM_COLS-1:0]            colEn
);

  generate
    for (genvar c = 0; c < NUM_COLS; c++) begin : gCol
      logic [LEVEL_BITS-1:0] level;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          level <= '0;
        end else if (strobes.loadPixels) begin
          level <= rowData[c*LEVEL_BITS +: LEVEL_BITS];
        end
      end

      assign colEn[c] = strobes.scanOn && (tick < level);
    end
  endgenerate

endmodule

// File: rtl/rowScanPwm.sv
module rowScanPwm
  import rowScanPkg::*;
#(
  parameter int NUM_ROWS   = 8,
  parameter int NUM_COLS   = 8,
  parameter int LEVEL_BITS = 4,
  parameter int TICK_DIV   = 3,
  localparam int ROW_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  output logic [ROW_W-1:0]               fbRowAddr,
  input  logic [NUM_COLS*LEVEL_BITS-1:0] fbRowData,
  output logic [NUM_COLS-1:0]            colEn,
  output logic                           srData,
  output logic                           srClk,
  output logic                           srLatch,
  output logic                           frameEnd
);

  scanStrobes_t          strobes;
  logic [LEVEL_BITS-1:0] tick;

  rowScanCtrl #(
    .NUM_ROWS  (NUM_ROWS),
    .LEVEL_BITS(LEVEL_BITS),
    .TICK_DIV  (TICK_DIV)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .tick    (tick),
    .rowIdx  (fbRowAddr),
    .srData  (srData),
    .srClk   (srClk),
    .srLatch (srLatch),
    .frameEnd(frameEnd)
  );

  rowScanData #(
    .NUM_COLS  (NUM_COLS),
    .LEVEL_BITS(LEVEL_BITS)
  ) data (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .tick   (tick),
    .rowData(fbRowData),
    .colEn  (colEn)
  );

endmodule

// File: rtl/rowScanPwmChecker.sv
module rowScanPwmChecker #(
  parameter int NUM_COLS = 8,
  parameter int ROW_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [ROW_W-1:0]    fbRowAddr,
  input logic [NUM_COLS-1:0] colEn,
  input logic                srClk,
  input logic                srLatch,
  input logic                frameEnd
);

  AST_CLK_NOT_WITH_LATCH: assert property (@(posedge clk) disable iff (!rstN) !(srClk && srLatch)); // R2
  AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) srLatch |=> !srLatch); // R2
  AST_LATCH_AFTER_CLK: assert property (@(posedge clk) disable iff (!rstN) $rose(srLatch) |-> $past(srClk)); // R2
  AST_ADDR_HELD_AT_LATCH: assert property (@(posedge clk) disable iff (!rstN) $rose(srLatch) |-> $stable(fbRowAddr)); // R4
  AST_BLANK_DURING_LOAD: assert property (@(posedge clk) disable iff (!rstN) (srClk || srLatch) |-> (colEn == '0)); // R7
  AST_FRAME_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) frameEnd |=> !frameEnd); // R8
  AST_FRAME_WRAPS_ROW: assert property (@(posedge clk) disable iff (!rstN) frameEnd |=> (fbRowAddr == '0)); // R3

endmodule

bind rowScanPwm rowScanPwmChecker #(
  .NUM_COLS(NUM_COLS),
  .ROW_W   (ROW_W)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .fbRowAddr(fbRowAddr),
  .colEn    (colEn),
  .srClk    (srClk),
  .srLatch  (srLatch),
  .frameEnd (frameEnd)
);

// File: tb/rowScanPwm_test.sv
module rowScanPwm_test;

  localparam int NR = 8;
  localparam int NC = 8;
  localparam int LB = 4;
  localparam int DIV = 3;
  localparam int SLOT = 15 * DIV;
  localparam int FRAMES = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] fbRowAddr;
  logic [NC*LB-1:0] fbRowData;
  logic [NC-1:0] colEn;
  logic srData, srClk, srLatch, frameEnd;

  logic [3:0] fb [NR][NC];

  int nTests = 0;
  int nFail = 0;
  int frameCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++) fbRowData[c*LB +: LB] = fb[fbRowAddr][c];
  end

  rowScanPwm #(.NUM_ROWS(NR), .NUM_COLS(NC), .LEVEL_BITS(LB), .TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .fbRowAddr(fbRowAddr), .fbRowData(fbRowData),
    .colEn(colEn), .srData(srData), .srClk(srClk), .srLatch(srLatch), .frameEnd(frameEnd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] patternValue(int f, int r, int c);
    case (f)
      0: return 4'((r * NC + c) % 16);
      1: return 4'd15;
      2: return 4'd0;
      3: return ((r + c) % 2 == 0) ? 4'd0 : 4'd15;
      default: return 4'($urandom % 16);
    endcase
  endfunction

  // Bench model of the external row register and the column-timing reference
  logic [NR-1:0] sr;
  int shiftCnt, sinceLatch, curRow, posErr, blankErr, pokes;
  bit havePrev, firstCycle;
  int expVals [NC];
  int onCnt [NC];

  always @(negedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++) fb[r][c] = patternValue(0, r, c);
      sr = '0; shiftCnt = 0; sinceLatch = -1; curRow = 0;
      posErr = 0; blankErr = 0; pokes = 0; havePrev = 1'b0; firstCycle = 1'b1;
      for (int c = 0; c < NC; c++) begin expVals[c] = 0; onCnt[c] = 0; end
    end else begin
      if (firstCycle) begin
        check(colEn == '0 && !srClk && !srLatch && !frameEnd, "R1 first cycle",
              int'({colEn, srClk, srLatch, frameEnd}), 0);
        firstCycle = 1'b0;
      end
      if (srClk) begin
        sr = {sr[NR-2:0], srData};
        shiftCnt++;
      end
      if (sinceLatch >= 0) sinceLatch++;
      if (sinceLatch >= 1 && sinceLatch <= SLOT) begin
        for (int c = 0; c < NC; c++) begin
          if (colEn[c] !== (((sinceLatch - 1) / DIV) < expVals[c])) posErr++;
          if (colEn[c]) onCnt[c]++;
        end
      end else if (colEn != '0) begin
        blankErr++;
      end
      if (frameEnd) begin
        check(curRow == NR - 1 && sinceLatch == SLOT, "R8 frameEnd placement",
              curRow * 1000 + sinceLatch, (NR - 1) * 1000 + SLOT);
        frameCount++;
      end
      if (srLatch) begin
        automatic int expRow = havePrev ? (curRow + 1) % NR : 0;
        if (havePrev) begin
          for (int c = 0; c < NC; c++) begin
            automatic string tag = (expVals[c] == 0 || expVals[c] == 15) ? "R6 on-time" :
                                   (pokes > 0 ? "R9 on-time" : "R5 on-time");
            check(onCnt[c] == expVals[c] * DIV, tag, onCnt[c], expVals[c] * DIV);
          end
          check(posErr == 0, "R5 pulse position", posErr, 0);
          check(blankErr == 0, "R7 blanking", blankErr, 0);
        end else begin
          check(blankErr == 0, "R1 dark before first row", blankErr, 0);
        end
        check(shiftCnt == NR, "R2 shift count", shiftCnt, NR);
        check(sr == NR'(1 << expRow), havePrev ? "R3 row pattern" : "R1 first row", int'(sr), 1 << expRow);
        check(int'(fbRowAddr) == expRow, "R4 row address", int'(fbRowAddr), expRow);
        curRow = expRow;
        for (int c = 0; c < NC; c++) begin expVals[c] = int'(fb[expRow][c]); onCnt[c] = 0; end
        posErr = 0; blankErr = 0; pokes = 0; shiftCnt = 0; sinceLatch = 0; havePrev = 1'b1;
      end else begin
        // R9: frame swap on frameEnd plus random mid-slot pokes
        if (frameEnd) begin
          for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) fb[r][c] = patternValue(frameCount, r, c);
          pokes++;
        end else if (frameCount >= 4 && ($urandom % 6) == 0) begin
          fb[$urandom % NR][$urandom % NC] = 4'($urandom % 16);
          pokes++;
        end
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    check(colEn == '0 && !srClk && !srLatch && !frameEnd, "R1 in reset",
          int'({colEn, srClk, srLatch, frameEnd}), 0);
    rstN = 1'b1;
    while (frameCount < FRAMES) @(negedge clk);
    repeat (20) @(negedge clk);
    check(frameCount == FRAMES, "R8 one pulse per frame", frameCount, FRAMES);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      check(1'b0, "watchdog", frameCount, FRAMES);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule